// File: doc/BRIEF.md
# Receive Sampling Tuning Sweep Engine

This engine finds a good receive sampling delay for a high-speed memory card link. After a start pulse it steps a tap index upward from zero through a fixed last tap. For each tap it applies the setting to the sampling logic twice and then asks an external agent to run one tuning transfer. The agent answers with a pass/fail result and a valid flag. The engine records the longest run of consecutive passing taps. At the end it applies the tap at the centre of that run.

A tap is applied through a self-clearing busy bit. A one-cycle `commit` strobe sets `commit_busy`. The bit clears by itself a fixed number of cycles later. Every tap, including the final one, is applied twice, and the second application starts only after the first has cleared. If no tap passes, the engine raises `error` and applies no final tap. `done` or `error` stays high until the next accepted start.

Top module: `rx_tune_sweep`

## Requirements
- R1: After reset, `commit`, `commit_busy`, `trial_req`, `done` and `error` are low, and `tune_val` and `final_val` are 0.
- R2: Each `commit` pulse drives `commit_busy` high for exactly ACK_LAT+1 cycles, counting the commit cycle. `tune_val` does not change while the bit is high.
- R3: Each applied tap gets exactly two `commit` pulses. At least one cycle with `commit_busy` low separates them.
- R4: An accepted start sweeps taps 0,1,…,LAST_TAP (39 by default) in ascending order, with exactly one `trial_req` pulse per tap after that tap's second commit. `tune_val` never exceeds LAST_TAP.
- R5: A `res_valid` is taken only while the engine is waiting for the result of an issued trial. At any other time it has no effect.
- R6: A passing result extends the current run and a failing one resets it to zero. The applied final tap is the last tap of the longest run minus half that run's length, rounded down.
- R7: When two runs have equal length, the earlier run is kept.
- R8: If no tap passes, `error` rises, no further commit occurs, and `final_val` stays 0.
- R9: On success the final tap is committed twice. `done` then rises, and `tune_val` and `final_val` both show the final tap.
- R10: A start pulse while a sweep is in progress is ignored.
- R11: `done` and `error` hold until the next accepted start, which clears them in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (taken only when idle) |
| res_valid | input | 1 | Trial result is present |
| res_pass | input | 1 | Trial result: 1 pass, 0 fail |
| tune_val | output | TUNE_W | Tap currently applied to the sampling logic |
| commit | output | 1 | One-cycle strobe that applies `tune_val` |
| commit_busy | output | 1 | Self-clearing apply-in-progress bit |
| trial_req | output | 1 | One-cycle request for a tuning transfer |
| done | output | 1 | Sweep finished with a final tap applied |
| error | output | 1 | Sweep finished with no passing tap |
| final_val | output | TUNE_W | Chosen tap, valid while `done` |

## Verification
A corrupted run counter or best-run record shows up only at the end of the sweep, as a wrong `final_val` and a wrong tap on the last commit pair. That takes up to forty taps to appear. Each commit is therefore matched on the cycle it happens against a queue of expected taps. A wrong step in the apply handshake shows up within a few cycles, either as a busy length other than ACK_LAT+1 or as a wrong commit count before a trial. Spurious result pulses during apply windows would bend the window, so the runs include them.

// File: rtl/rx_tune_sweep.sv
module rx_tune_sweep #(
  parameter int TUNE_W   = 6,
  parameter int LAST_TAP = 39,
  parameter int ACK_LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              res_valid,
  input  logic              res_pass,
  output logic [TUNE_W-1:0] tune_val,
  output logic              commit,
  output logic              commit_busy,
  output logic              trial_req,
  output logic              done,
  output logic              error,
  output logic [TUNE_W-1:0] final_val
);
  localparam int CW = (ACK_LAT > 1) ? $clog2(ACK_LAT) : 1;
  localparam logic [TUNE_W-1:0] LAST = TUNE_W'(LAST_TAP);

  typedef enum logic [2:0] {S_IDLE, S_CMT, S_WAIT, S_REL, S_TRIAL, S_RES, S_PICK} st_t;
  st_t st;

  logic [TUNE_W-1:0] tap, cur, best, best_end;
  logic [CW-1:0]     cnt;
  logic              second, fin;
  wire  [TUNE_W-1:0] cur_inc = cur + 1'b1;

  assign tune_val    = tap;
  assign commit      = (st == S_CMT);
  assign commit_busy = (st == S_CMT) || (st == S_WAIT);
  assign trial_req   = (st == S_TRIAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tap <= '0; cur <= '0; best <= '0; best_end <= '0;
      cnt <= '0; second <= 1'b0; fin <= 1'b0;
      done <= 1'b0; error <= 1'b0; final_val <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tap <= '0; cur <= '0; best <= '0; best_end <= '0;
          second <= 1'b0; fin <= 1'b0;
          done <= 1'b0; error <= 1'b0; final_val <= '0;
          st <= S_CMT;
        end
        S_CMT: begin
          cnt <= CW'(ACK_LAT - 1);
          st  <= S_WAIT;
        end
        S_WAIT: if (cnt == '0) st <= S_REL; else cnt <= cnt - 1'b1;
        S_REL: if (!second) begin
          second <= 1'b1;
          st     <= S_CMT;
        end else begin
          second <= 1'b0;
          if (fin) begin
            done      <= 1'b1;
            final_val <= tap;
            st        <= S_IDLE;
          end else st <= S_TRIAL;
        end
        S_TRIAL: st <= S_RES;
        S_RES: if (res_valid) begin
          if (res_pass) begin
            cur <= cur_inc;
            if (cur_inc > best) begin
              best     <= cur_inc;
              best_end <= tap;
            end
          end else cur <= '0;
          if (tap == LAST) st <= S_PICK;
          else begin
            tap <= tap + 1'b1;
            st  <= S_CMT;
          end
        end
        S_PICK: if (best == '0) begin
          error <= 1'b1;
          st    <= S_IDLE;
        end else begin
          tap <= best_end - (best >> 1);
          fin <= 1'b1;
          st  <= S_CMT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_tap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tune_val <= LAST);
  p_commit_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(commit_busy));
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_busy && !commit) |-> $stable(tune_val));
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!commit && final_val == '0));
  p_flag_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_done_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (tune_val == final_val));
endmodule

// File: tb/tb_rx_tune_sweep.sv
module tb_rx_tune_sweep;
  localparam int TW = 6, LAST = 39, LAT = 3;
  logic clk = 0, rst_n = 0, start = 0, res_valid = 0, res_pass = 0;
  logic [TW-1:0] tune_val, final_val;
  logic commit, commit_busy, trial_req, done, error;

  rx_tune_sweep #(.TUNE_W(TW), .LAST_TAP(LAST), .ACK_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .res_valid(res_valid), .res_pass(res_pass),
    .tune_val(tune_val), .commit(commit), .commit_busy(commit_busy), .trial_req(trial_req),
    .done(done), .error(error), .final_val(final_val));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [LAST:0] pat;
  bit spur_en = 0, running = 0;
  int exp_q[$];
  int pend = 0, lat_tap = 0, bcnt = 0, ccnt = 0, trials = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // result agent: answers each trial two cycles later; optional spurious results during apply
  initial forever begin
    @(negedge clk);
    res_valid = 0; res_pass = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin res_valid = 1; res_pass = pat[lat_tap]; end
    end else if (trial_req) begin
      pend = 2; lat_tap = int'(tune_val);
    end else if (spur_en && commit_busy && !commit) begin
      res_valid = 1; res_pass = 1;  // R5: must be ignored
    end
  end

  // per-cycle comparison against the expected apply/trial sequence
  initial forever begin
    @(negedge clk);
    if (rst_n && running) begin
      if (commit_busy) bcnt++;
      else if (bcnt > 0) begin
        chk(bcnt == LAT + 1, "R2 busy length", bcnt, LAT + 1);
        bcnt = 0;
      end
      if (commit) begin
        ccnt++;
        if (exp_q.size() == 0) chk(0, "R8/R9 unexpected commit", int'(tune_val), -1);
        else begin
          automatic int e = exp_q.pop_front();
          chk(int'(tune_val) == e, "R4/R9 commit tap", int'(tune_val), e);
        end
      end
      if (trial_req) begin
        chk(ccnt == 2, "R3 commits per tap", ccnt, 2);
        chk(int'(tune_val) == trials, "R4 trial order", int'(tune_val), trials);
        ccnt = 0; trials++;
      end
    end
  end

  task automatic run(logic [LAST:0] p, bit spur, bit mid_start, string name);
    int cur = 0, best = 0, bend = 0, fv;
    pat = p; spur_en = spur;
    for (int t = 0; t <= LAST; t++) begin
      if (p[t]) begin
        cur++;
        if (cur > best) begin best = cur; bend = t; end  // R7: strictly longer only
      end else cur = 0;
    end
    fv = bend - best / 2;
    exp_q.delete();
    for (int t = 0; t <= LAST; t++) begin exp_q.push_back(t); exp_q.push_back(t); end
    if (best > 0) begin exp_q.push_back(fv); exp_q.push_back(fv); end
    trials = 0; ccnt = 0; bcnt = 0; running = 1;
    start = 1; @(negedge clk); start = 0;
    chk(!done && !error, {"R11 flags cleared ", name}, {done, error}, 0);
    if (mid_start) begin
      repeat (100) @(negedge clk);
      start = 1; @(negedge clk); start = 0;  // R10
    end
    for (int i = 0; i < 5000 && !(done || error); i++) @(negedge clk);
    if (best == 0) begin
      chk(error && !done, {"R8 error raised ", name}, {done, error}, 1);
      chk(final_val == 0, "R8 no final value", int'(final_val), 0);
    end else begin
      chk(done && !error, {"R9 done raised ", name}, {done, error}, 2);
      chk(int'(final_val) == fv, {"R6/R7 final tap ", name}, int'(final_val), fv);
      chk(int'(tune_val) == fv, "R9 applied tap", int'(tune_val), fv);
    end
    chk(exp_q.size() == 0, {"R4/R9 commits left ", name}, exp_q.size(), 0);
    chk(trials == LAST + 1, {"R4 trial count ", name}, trials, LAST + 1);
    repeat (6) @(negedge clk);
    chk(done == (best > 0) && error == (best == 0), "R11 flags held", {done, error}, (best > 0) ? 2 : 1);
    chk(!commit_busy && !trial_req, "R10/R11 idle after finish", {commit_busy, trial_req}, 0);
    running = 0;
  endtask

  initial begin
    logic [LAST:0] p;
    repeat (3) @(negedge clk);
    chk(!commit && !commit_busy && !trial_req && !done && !error, "R1 reset outputs",
        {commit, commit_busy, trial_req, done, error}, 0);
    chk(tune_val == 0 && final_val == 0, "R1 reset values", int'(tune_val), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!commit && !done && !error, "R1 idle after reset", {commit, done, error}, 0);
    run('1, 0, 0, "all pass");
    run('0, 1, 0, "none pass");
    p = '0; for (int t = 10; t <= 20; t++) p[t] = 1;
    run(p, 1, 0, "single window");
    p = '0; for (int t = 3; t <= 7; t++) p[t] = 1; for (int t = 20; t <= 24; t++) p[t] = 1;
    run(p, 0, 0, "tie");
    p = '0; p[0] = 1;
    run(p, 0, 0, "first tap only");
    p = '0; p[LAST] = 1;
    run(p, 1, 1, "last tap only");
    p = '0; for (int t = 2; t <= 4; t++) p[t] = 1; for (int t = 30; t <= 37; t++) p[t] = 1; p[12] = 1;
    run(p, 0, 1, "longer later");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule